// File: doc/BRIEF.md
# Strobe write capture bridge

This block sits on the slave side of an asynchronous 68000-style extension bus. That bus has no bus clock and no wait-state handshake, so a cycle cannot be stretched. The block samples the address, chip select, read/write, address strobe, data strobe and data lines on its own fast local clock. It only takes part in a cycle when the address decodes to its own window.

On a matching write, the data word is committed into a holding register when the strobes are released. The same event raises a sticky interrupt toward a slow microcontroller. The microcontroller reads the held word through a local port and pulses an acknowledge. If a second write arrives before that acknowledge, an overrun flag is raised.

Matching reads return either the held word or a status word. The block asserts an enable for the data pins during such a read, and the pad logic releases the pins whenever that enable is low.

Top module: `strobe_write_bridge`

## Requirements
- R1: While rst_ni is low, and after it rises, irq_o, overrun_o and bus_data_oe_o are 0 and hold_data_o is all zeros.
- R2: A qualified write updates hold_data_o with the word on bus_data_i. A qualified write is one with bus_cs_ni, bus_as_ni and bus_ds_ni all low, bus_rw_i = 0, bus_addr_i[AW-1:1] equal to BASE_ADDR[AW-1:1], and bus_addr_i[0] = 0. The update takes effect on the third rising clock edge after the strobes are released, and hold_data_o does not change before that.
- R3: A qualified write sets irq_o on that same edge. irq_o then stays at 1 until a clock edge at which ack_i is 1.
- R4: Writes leave hold_data_o, irq_o and overrun_o unchanged in each of these cases: the address is outside the window, the address is in the window with bit 0 = 1, or chip select is high.
- R5: A qualified write that commits while irq_o is 1, with ack_i at 0 on that edge, sets overrun_o. overrun_o clears only on an edge where ack_i is 1.
- R6: bus_data_oe_o rises on the third rising edge after chip select, both strobes, bus_rw_i = 1 and an address in the window are all present. It falls on the third rising edge after any of them goes away. It stays 0 for every other cycle.
- R7: While bus_data_oe_o is 1, bus_data_o carries the following, selected by the address bit 0 of the read. Bit 0 = 0 gives the held word. Bit 0 = 1 gives the status word, with pending in bit 0, overrun in bit 1 and zeros in all other bits. While bus_data_oe_o is 0, bus_data_o is all zeros.
- R8: When a qualified write commits on the same edge where ack_i is 1, irq_o stays 1, overrun_o becomes 0, and hold_data_o takes the new word.
- R9: A cycle in which the data strobe is low but the address strobe stays high has no effect: no write commits and the data pins are not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | AW | Bus address |
| bus_cs_ni | input | 1 | Chip select, active low |
| bus_as_ni | input | 1 | Address strobe, active low |
| bus_ds_ni | input | 1 | Data strobe, active low |
| bus_rw_i | input | 1 | 1 = read, 0 = write |
| bus_data_i | input | DW | Bus write data |
| bus_data_o | output | DW | Bus read data |
| bus_data_oe_o | output | 1 | Data pin drive enable |
| ack_i | input | 1 | Local acknowledge pulse, synchronous to clk_i |
| irq_o | output | 1 | Sticky interrupt (write pending) |
| overrun_o | output | 1 | Write arrived before acknowledge |
| hold_data_o | output | DW | Last word written |

## Verification
Every bus input passes through two synchronizer flops and one decode register. A write therefore commits on the third rising edge after the strobe release, and the read enable follows the strobe on the third edge after each change. An acknowledge takes effect on the first rising edge that sees it.

The bench changes bus signals only on falling edges, so this latency is exact rather than a window. The reference model schedules each effect on that precise edge. Every output is then compared at every falling edge, which catches a result that arrives one cycle early as well as one that arrives late.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int unsigned ST_PEND_BIT = 0;
  localparam int unsigned ST_OVR_BIT  = 1;

  typedef struct packed {
    logic as_n;
    logic ds_n;
    logic cs_n;
    logic rw;
  } bus_ctl_t;
endpackage

// File: rtl/sbw_sync.sv
module sbw_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[0] <= RST_VAL;
        else         stg_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sbw_front.sv
module sbw_front #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16,
  parameter logic [AW-1:0] BASE_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sbw_pkg::bus_ctl_t ctl_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_pulse_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_en_o,
  output logic          rd_sel_o
);
  logic          active, match;
  logic          act_q, lat_rw_q;
  logic [AW-1:0] lat_addr_q;
  logic [DW-1:0] lat_data_q;

  // cycle window: chip select and both strobes low
  assign active = ~ctl_i.as_n & ~ctl_i.ds_n & ~ctl_i.cs_n;
  assign match  = (addr_i[AW-1:1] == BASE_ADDR[AW-1:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      lat_rw_q   <= 1'b1;
      lat_addr_q <= '0;
      lat_data_q <= '0;
      rd_en_o    <= 1'b0;
      rd_sel_o   <= 1'b0;
    end else begin
      act_q    <= active;
      rd_en_o  <= active & ctl_i.rw & match;
      rd_sel_o <= addr_i[0];
      // keep the last in-window view; used at the trailing edge
      if (active) begin
        lat_rw_q   <= ctl_i.rw;
        lat_addr_q <= addr_i;
        lat_data_q <= data_i;
      end
    end
  end

  assign wr_pulse_o = act_q & ~active & ~lat_rw_q & ~lat_addr_q[0] &
                      (lat_addr_q[AW-1:1] == BASE_ADDR[AW-1:1]);
  assign wr_data_o  = lat_data_q;
endmodule

// File: rtl/sbw_regs.sv
module sbw_regs #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ack_i,
  output logic [DW-1:0] hold_o,
  output logic [DW-1:0] status_o,
  output logic          pend_o,
  output logic          ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= '0;
      pend_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (wr_i) hold_o <= wr_data_i;
      pend_o <= (pend_o & ~ack_i) | wr_i;
      ovr_o  <= (ovr_o & ~ack_i) | (wr_i & pend_o & ~ack_i);
    end
  end

  always_comb begin
    status_o = '0;
    status_o[sbw_pkg::ST_PEND_BIT] = pend_o;
    status_o[sbw_pkg::ST_OVR_BIT]  = ovr_o;
  end
endmodule

// File: rtl/strobe_write_bridge.sv
module strobe_write_bridge #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [AW-1:0] BASE_ADDR = 8'h40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_cs_ni,
  input  logic          bus_as_ni,
  input  logic          bus_ds_ni,
  input  logic          bus_rw_i,
  input  logic [DW-1:0] bus_data_i,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe_o,
  input  logic          ack_i,
  output logic          irq_o,
  output logic          overrun_o,
  output logic [DW-1:0] hold_data_o
);
  localparam int unsigned CW = $bits(sbw_pkg::bus_ctl_t);
  localparam int unsigned SW = CW + AW + DW;
  localparam logic [SW-1:0] SYNC_RST = {4'b1110, {(AW+DW){1'b0}}};

  sbw_pkg::bus_ctl_t ctl_raw, ctl_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s, wr_data, status;
  logic          wr_pulse, rd_en, rd_sel;

  assign ctl_raw = '{as_n: bus_as_ni, ds_n: bus_ds_ni, cs_n: bus_cs_ni, rw: bus_rw_i};

  sbw_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ctl_raw, bus_addr_i, bus_data_i}),
    .q_o   ({ctl_s, addr_s, data_s})
  );

  sbw_front #(.AW(AW), .DW(DW), .BASE_ADDR(BASE_ADDR)) u_front (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_i     (ctl_s),
    .addr_i    (addr_s),
    .data_i    (data_s),
    .wr_pulse_o(wr_pulse),
    .wr_data_o (wr_data),
    .rd_en_o   (rd_en),
    .rd_sel_o  (rd_sel)
  );

  sbw_regs #(.DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_pulse),
    .wr_data_i(wr_data),
    .ack_i    (ack_i),
    .hold_o   (hold_data_o),
    .status_o (status),
    .pend_o   (irq_o),
    .ovr_o    (overrun_o)
  );

  assign bus_data_oe_o = rd_en;
  assign bus_data_o    = rd_en ? (rd_sel ? status : hold_data_o) : '0;
endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_i,
  input logic          irq_o,
  input logic          overrun_o,
  input logic [DW-1:0] hold_data_o
);
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> irq_o);  // R3
  AST_HOLD_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hold_data_o) |-> irq_o);  // R2
  AST_OVR_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> irq_o);  // R5
  AST_OVR_RISE_AFTER_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(irq_o) && !$past(ack_i));  // R5
  AST_ACK_CLEARS_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !overrun_o);  // R8
endmodule

bind strobe_write_bridge sbw_checker #(.DW(DW)) u_sbw_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .irq_o      (irq_o),
  .overrun_o  (overrun_o),
  .hold_data_o(hold_data_o)
);

// File: tb/strobe_write_bridge_test.sv
`timescale 1ns/1ps
module strobe_write_bridge_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] BASE = 8'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic cs_n = 1'b1, as_n = 1'b1, ds_n = 1'b1, rw = 1'b1, ack = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout, hold;
  logic oe, irq, ovr;

  int total = 0, bad = 0;

  strobe_write_bridge #(.AW(AW), .DW(DW), .BASE_ADDR(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_cs_ni(cs_n),
    .bus_as_ni(as_n), .bus_ds_ni(ds_n), .bus_rw_i(rw), .bus_data_i(din),
    .bus_data_o(dout), .bus_data_oe_o(oe), .ack_i(ack), .irq_o(irq),
    .overrun_o(ovr), .hold_data_o(hold)
  );

  always #2 clk = ~clk;  // 250 MHz

  // reference model
  int          wr_due = 0;
  logic [DW-1:0] wr_val = '0;
  logic [DW-1:0] m_hold = '0;
  logic        m_pend = 1'b0, m_ovr = 1'b0;
  logic [2:0]  en_pipe = '0, sel_pipe = '0;

  always @(posedge clk) begin
    logic wr_now, rd_v;
    if (!rst_n) begin
      m_hold = '0; m_pend = 0; m_ovr = 0; en_pipe = '0; sel_pipe = '0;
    end else begin
      wr_now = 1'b0;
      if (wr_due > 0) begin
        wr_due = wr_due - 1;
        if (wr_due == 0) wr_now = 1'b1;
      end
      rd_v = !cs_n && !ds_n && !as_n && rw && (addr[AW-1:1] == BASE[AW-1:1]);
      en_pipe  = {en_pipe[1:0], rd_v};
      sel_pipe = {sel_pipe[1:0], addr[0]};
      m_ovr  = (m_ovr && !ack) || (wr_now && m_pend && !ack);
      m_pend = (m_pend && !ack) || wr_now;
      if (wr_now) m_hold = wr_val;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [DW-1:0] exp_d;
    if (rst_n) begin
      exp_d = '0;
      if (en_pipe[2]) begin
        if (sel_pipe[2]) begin exp_d[0] = m_pend; exp_d[1] = m_ovr; end
        else exp_d = m_hold;
      end
      chk("R2 hold", hold, m_hold);
      chk("R3 irq", {15'b0, irq}, {15'b0, m_pend});
      chk("R5 overrun", {15'b0, ovr}, {15'b0, m_ovr});
      chk("R6 oe", {15'b0, oe}, {15'b0, en_pipe[2]});
      chk("R7 rdata", dout, exp_d);
    end
  end

  task automatic bus_cycle(input logic [AW-1:0] a, input logic rd, input logic [DW-1:0] d,
                           input logic use_cs, input logic use_as, input logic ack_sync,
                           output logic [DW-1:0] seen);
    int su, w, h;
    seen = '0;
    @(negedge clk);
    addr = a; rw = rd; din = d; cs_n = !use_cs;
    su = $urandom_range(1, 3);
    repeat (su) @(negedge clk);
    as_n = !use_as; ds_n = 1'b0;
    w = $urandom_range(18, 25);  // 72..100 ns strobe
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (i == 8) seen = dout;
    end
    ds_n = 1'b1; as_n = 1'b1;
    if (use_cs && use_as && !rd && a[AW-1:1] == BASE[AW-1:1] && !a[0]) begin
      wr_due = 3; wr_val = d;
    end
    h = ack_sync ? 4 : $urandom_range(1, 3);
    for (int i = 1; i <= h; i++) begin
      @(negedge clk);
      if (ack_sync && i == 2) ack = 1'b1;
      if (i == 3) ack = 1'b0;
    end
    cs_n = 1'b1; addr = AW'($urandom); din = DW'($urandom); rw = 1'($urandom);
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] s;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {15'b0, irq}, 16'h0);
    chk("R1 ovr in reset", {15'b0, ovr}, 16'h0);
    chk("R1 oe in reset", {15'b0, oe}, 16'h0);
    chk("R1 hold in reset", hold, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 hold after reset", hold, 16'h0);

    bus_cycle(8'h40, 1'b0, 16'hA5C3, 1, 1, 0, s);
    repeat (4) @(negedge clk);
    chk("R2 written word", hold, 16'hA5C3);
    chk("R3 irq set", {15'b0, irq}, 16'h1);

    bus_cycle(8'h40, 1'b1, 16'h0, 1, 1, 0, s);
    chk("R7 read offset0", s, 16'hA5C3);
    bus_cycle(8'h41, 1'b1, 16'h0, 1, 1, 0, s);
    chk("R7 read status pend", s, 16'h0001);

    bus_cycle(8'h40, 1'b0, 16'h1234, 1, 1, 0, s);
    repeat (4) @(negedge clk);
    chk("R5 overrun set", {15'b0, ovr}, 16'h1);
    bus_cycle(8'h41, 1'b1, 16'h0, 1, 1, 0, s);
    chk("R7 read status pend+ovr", s, 16'h0003);

    pulse_ack();
    @(negedge clk);
    chk("R3 irq cleared by ack", {15'b0, irq}, 16'h0);
    chk("R5 ovr cleared by ack", {15'b0, ovr}, 16'h0);

    bus_cycle(8'h41, 1'b0, 16'hDEAD, 1, 1, 0, s);
    bus_cycle(8'h52, 1'b0, 16'hBEEF, 1, 1, 0, s);
    bus_cycle(8'h40, 1'b0, 16'hCAFE, 0, 1, 0, s);
    repeat (4) @(negedge clk);
    chk("R4 ignored writes hold", hold, 16'h1234);
    chk("R4 ignored writes irq", {15'b0, irq}, 16'h0);

    bus_cycle(8'h40, 1'b0, 16'h7777, 1, 0, 0, s);
    repeat (4) @(negedge clk);
    chk("R9 no address strobe hold", hold, 16'h1234);
    chk("R9 no address strobe irq", {15'b0, irq}, 16'h0);
    bus_cycle(8'h40, 1'b1, 16'h0, 1, 0, 0, s);
    chk("R9 no address strobe read", s, 16'h0);
    bus_cycle(8'h62, 1'b1, 16'h0, 1, 1, 0, s);
    chk("R6 foreign read not driven", s, 16'h0);

    bus_cycle(8'h40, 1'b0, 16'h0F0F, 1, 1, 0, s);
    bus_cycle(8'h40, 1'b0, 16'hF00D, 1, 1, 1, s);
    repeat (2) @(negedge clk);
    chk("R8 pend kept", {15'b0, irq}, 16'h1);
    chk("R8 ovr cleared", {15'b0, ovr}, 16'h0);
    chk("R8 new word", hold, 16'hF00D);
    pulse_ack();

    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] a;
      case ($urandom_range(0, 2))
        0: a = 8'h40;
        1: a = 8'h41;
        default: a = AW'($urandom);
      endcase
      bus_cycle(a, 1'($urandom), DW'($urandom), 1'($urandom_range(0, 7) != 0), 1, 0, s);
      if ($urandom_range(0, 3) == 0) pulse_ack();
    end
    repeat (6) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule